// File: doc/BRIEF.md
# Strobed Line Hold Register with Dot-Inversion Polarity

This block sits between the column sampling stage of a display source driver and its per-column digital-to-analog conversion. A whole line of sampled 8-bit gray codes is presented on a wide input bus. On the rising edge of a line strobe, every code is copied at once into a hold register and stays there for the whole line period. While it is copied, each code can be bitwise complemented. One control input does this for the columns fed from the first input port and a second does it for the columns fed from the second port.

Each output carries a drive-polarity bit. The bit selects the high or the low reference bank, and neighbouring outputs always take opposite banks. A reversal input is captured on every clock while the strobe is high, and it flips the whole pattern line by line. For each output the block also splits the held code into a 3-bit reference segment index and a 5-bit interpolation step. It raises a flag when the code lies in the top segment, whose steps are not evenly spaced, so the converter can switch to its uneven step mapping.

Top module: `dotInvLineLatch`

## Requirements
- R1: The first clock edge at which `lineStrobe` is sampled high (after it was sampled low) copies every code of `sampleLine` into `heldCode`, visible after that edge. Output o uses bits [8o+7:8o].
- R2: `heldCode` changes only on such a rising-strobe edge. Changes of `sampleLine` while the strobe stays high or stays low have no effect.
- R3: `polPos` bits of any two adjacent outputs are always opposite. `polPos`=1 means the high reference bank.
- R4: `lineRev` is captured at every edge where `lineStrobe` is high, and the last captured value applies to the whole line. When it is 1, output 0 is positive and output o has `polPos[o]` = 1 exactly for even o. When it is 0, all bits are the inverse.
- R5: Changes of `lineRev` while `lineStrobe` is low do not change `polPos`.
- R6: Outputs are grouped in triples (o/3). Even triples come from port A and odd triples from port B. At load, a code is stored bitwise complemented when the flag of its port (`polA` or `polB`) is 1, and unchanged when it is 0.
- R7: `segIdx` for output o is held code bits [7:5], and `segFrac` is bits [4:0].
- R8: `topSeg[o]` is 1 exactly when the segment index of output o is 7.
- R9: After reset all held codes are 0, and `polPos[o]` = 1 for even o and 0 for odd o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | Line transfer strobe |
| lineRev | input | 1 | Polarity reversal, captured while the strobe is high |
| polA | input | 1 | Complement enable for port-A columns |
| polB | input | 1 | Complement enable for port-B columns |
| sampleLine | input | NUM_OUT*8 | Sampled codes, output 0 in the low byte |
| heldCode | output | NUM_OUT*8 | Held codes |
| polPos | output | NUM_OUT | 1 = high reference bank |
| segIdx | output | NUM_OUT*3 | Segment index per output |
| segFrac | output | NUM_OUT*5 | Interpolation step per output |
| topSeg | output | NUM_OUT | Top-segment flag per output |

## Verification
The code transfer and the reversal capture can fall on the same clock edge: the rising-strobe edge both loads codes and samples `lineRev`. The bench keeps the strobe high for two cycles and changes `lineRev` and `sampleLine` between them. It then checks two things: that the codes come from the first strobe-high edge, and that the polarity comes from the second. Every table vector also sets `lineRev` together with the new line, so each load checks codes and polarity at once.

// File: rtl/lineLatchPkg.sv
package lineLatchPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadLine;  // rising edge of the line strobe
    logic capRev;    // strobe high: sample the reversal input
  } latchCtl_t;
endpackage

// File: rtl/lineLatchCtl.sv
module lineLatchCtl
  import lineLatchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineStrobe,
  output latchCtl_t ctl
);
  logic strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= lineStrobe;
  end

  always_comb begin
    ctl.loadLine = lineStrobe & ~strobeQ;
    ctl.capRev   = lineStrobe;
  end
endmodule

// File: rtl/lineLatchData.sv
module lineLatchData
  import lineLatchPkg::*;
#(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 8,
  parameter int SEG_W   = 3,
  parameter int GROUP   = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  latchCtl_t                   ctl,
  input  logic                        lineRev,
  input  logic                        polA,
  input  logic                        polB,
  input  logic [NUM_OUT*CODE_W-1:0]   sampleLine,
  output logic [NUM_OUT*CODE_W-1:0]   heldCode,
  output logic [NUM_OUT-1:0]          polPos,
  output logic [NUM_OUT*SEG_W-1:0]    segIdx,
  output logic [NUM_OUT*(CODE_W-SEG_W)-1:0] segFrac,
  output logic [NUM_OUT-1:0]          topSeg
);
  localparam int FRAC_W = CODE_W - SEG_W;

  logic revQ;

  // reset value 1 puts even outputs on the positive bank
  always_ff @(posedge clk) begin
    if (!rstN)           revQ <= 1'b1;
    else if (ctl.capRev) revQ <= lineRev;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
    localparam bit PORT_B = ((o / GROUP) % 2) == 1;
    localparam bit ODD    = (o % 2) == 1;

    logic [CODE_W-1:0] holdQ;
    logic              flipSel;

    assign flipSel = PORT_B ? polB : polA;

    always_ff @(posedge clk) begin
      if (!rstN)
        holdQ <= '0;
      else if (ctl.loadLine)
        holdQ <= sampleLine[o*CODE_W +: CODE_W] ^ {CODE_W{flipSel}};
    end

    assign heldCode[o*CODE_W +: CODE_W] = holdQ;
    assign polPos[o]                    = revQ ^ ODD;
    assign segIdx[o*SEG_W +: SEG_W]     = holdQ[CODE_W-1 -: SEG_W];
    assign segFrac[o*FRAC_W +: FRAC_W]  = holdQ[FRAC_W-1:0];
    assign topSeg[o]                    = &holdQ[CODE_W-1 -: SEG_W];
  end
endmodule

// File: rtl/dotInvLineLatch.sv
module dotInvLineLatch
  import lineLatchPkg::*;
#(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 8,
  parameter int SEG_W   = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              lineStrobe,
  input  logic                              lineRev,
  input  logic                              polA,
  input  logic                              polB,
  input  logic [NUM_OUT*CODE_W-1:0]         sampleLine,
  output logic [NUM_OUT*CODE_W-1:0]         heldCode,
  output logic [NUM_OUT-1:0]                polPos,
  output logic [NUM_OUT*SEG_W-1:0]          segIdx,
  output logic [NUM_OUT*(CODE_W-SEG_W)-1:0] segFrac,
  output logic [NUM_OUT-1:0]                topSeg
);
  latchCtl_t ctl;

  lineLatchCtl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStrobe (lineStrobe),
    .ctl        (ctl)
  );

  lineLatchData #(
    .NUM_OUT (NUM_OUT),
    .CODE_W  (CODE_W),
    .SEG_W   (SEG_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .lineRev    (lineRev),
    .polA       (polA),
    .polB       (polB),
    .sampleLine (sampleLine),
    .heldCode   (heldCode),
    .polPos     (polPos),
    .segIdx     (segIdx),
    .segFrac    (segFrac),
    .topSeg     (topSeg)
  );
endmodule

// File: rtl/dotInvLineLatchChk.sv
module dotInvLineLatchChk #(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 8,
  parameter int SEG_W   = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       lineStrobe,
  input logic                       lineRev,
  input logic [NUM_OUT*CODE_W-1:0]  heldCode,
  input logic [NUM_OUT-1:0]         polPos,
  input logic [NUM_OUT*SEG_W-1:0]   segIdx,
  input logic [NUM_OUT-1:0]         topSeg
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> $stable(heldCode));

  a_r2_high_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && $past(lineStrobe)) |=> $stable(heldCode));

  a_r3_neighbours: assert property (@(posedge clk) disable iff (!rstN)
    polPos[0] != polPos[1]);

  a_r4_rev_high: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && lineRev) |=> polPos[0]);

  a_r4_rev_low: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && !lineRev) |=> !polPos[0]);

  a_r5_pol_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> $stable(polPos));

  a_r8_top_flag: assert property (@(posedge clk) disable iff (!rstN)
    topSeg[0] == (segIdx[SEG_W-1:0] == {SEG_W{1'b1}}));
endmodule

bind dotInvLineLatch dotInvLineLatchChk #(
  .NUM_OUT (NUM_OUT),
  .CODE_W  (CODE_W),
  .SEG_W   (SEG_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lineStrobe (lineStrobe),
  .lineRev    (lineRev),
  .heldCode   (heldCode),
  .polPos     (polPos),
  .segIdx     (segIdx),
  .topSeg     (topSeg)
);

// File: tb/dotInvLineLatch_bench.sv
module dotInvLineLatch_bench;
  localparam int N  = 12;
  localparam int CW = 8;
  localparam int SW = 3;
  localparam int FW = CW - SW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStrobe = 1'b0, lineRev = 1'b0, polA = 1'b0, polB = 1'b0;
  logic [N*CW-1:0] sampleLine = '0;
  logic [N*CW-1:0] heldCode;
  logic [N-1:0]    polPos, topSeg;
  logic [N*SW-1:0] segIdx;
  logic [N*FW-1:0] segFrac;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dotInvLineLatch #(.NUM_OUT(N), .CODE_W(CW), .SEG_W(SW)) u_dotInvLineLatch (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineRev(lineRev),
    .polA(polA), .polB(polB), .sampleLine(sampleLine), .heldCode(heldCode),
    .polPos(polPos), .segIdx(segIdx), .segFrac(segFrac), .topSeg(topSeg)
  );

  // stimulus vectors: {seed[7:0], polA, polB, rev}
  localparam logic [10:0] VEC [6] = '{
    {8'h00, 1'b0, 1'b0, 1'b1},
    {8'h13, 1'b1, 1'b0, 1'b0},
    {8'hE0, 1'b0, 1'b1, 1'b1},
    {8'h7F, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b0},
    {8'h1F, 1'b1, 1'b1, 1'b1}
  };

  function automatic logic [7:0] lineByte(input logic [7:0] seed, input int o);
    return seed + 8'(o * 37);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic fillLine(input logic [7:0] seed);
    for (int o = 0; o < N; o++) sampleLine[o*CW +: CW] = lineByte(seed, o);
  endtask

  // compare all outputs against codes derived from a seed and flags
  task automatic checkLine(input string tag, input logic [7:0] seed,
                           input logic pa, input logic pb, input logic rv);
    for (int o = 0; o < N; o++) begin
      logic [7:0] e;
      logic flip;
      flip = (((o / 3) % 2) == 1) ? pb : pa;
      e = lineByte(seed, o) ^ {8{flip}};
      check({tag, " R1/R6 code"}, int'(heldCode[o*CW +: CW]), int'(e));
      check({tag, " R7 seg"}, int'(segIdx[o*SW +: SW]), int'(e[7:5]));
      check({tag, " R7 frac"}, int'(segFrac[o*FW +: FW]), int'(e[4:0]));
      check({tag, " R8 top"}, int'(topSeg[o]), int'(e[7:5] == 3'b111));
      check({tag, " R3/R4 pol"}, int'(polPos[o]), int'(rv ^ logic'(o % 2)));
    end
  endtask

  task automatic strobeLine;
    @(negedge clk) lineStrobe = 1'b1;
    @(negedge clk);
    @(negedge clk) lineStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    for (int o = 0; o < N; o++) begin
      check("R9 code", int'(heldCode[o*CW +: CW]), 0);
      check("R9 pol", int'(polPos[o]), int'((o % 2) == 0));
    end

    foreach (VEC[i]) begin
      fillLine(VEC[i][10:3]);
      polA = VEC[i][2]; polB = VEC[i][1]; lineRev = VEC[i][0];
      strobeLine();
      checkLine("vec", VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R2/R5: inputs move while the strobe is low
    fillLine(8'h55); lineRev = ~lineRev; polA = ~polA;
    repeat (3) @(negedge clk);
    checkLine("R2/R5 idle", VEC[5][10:3], VEC[5][2], VEC[5][1], VEC[5][0]);

    // R2/R4: load and reversal on the same edge, then changes mid-strobe
    fillLine(8'h40); polA = 1'b0; polB = 1'b0; lineRev = 1'b0;
    @(negedge clk) lineStrobe = 1'b1;
    @(negedge clk) begin fillLine(8'hC3); lineRev = 1'b1; end
    @(negedge clk) lineStrobe = 1'b0;
    @(negedge clk);
    checkLine("R2/R4 mid", 8'h40, 1'b0, 1'b0, 1'b1);

    // R9: reset again restores the initial state
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    for (int o = 0; o < N; o++) begin
      check("R9 rereset code", int'(heldCode[o*CW +: CW]), 0);
      check("R9 rereset pol", int'(polPos[o]), int'((o % 2) == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule